// File: doc/BRIEF.md
# Successive Approximation Conversion Sequencer

This block is the digital half of a successive approximation analog-to-digital converter. A start pulse opens a conversion. The controller then drives a trial code to an external DAC and reads back one comparator bit per step. That bit is high when the held sample lies above the DAC level. From these bits the controller builds the result most significant bit first and finishes with a one-cycle done strobe. The sample-and-hold, the comparator and the DAC sit outside the block.

A mode input chooses between two result scales. In binary mode, WIDTH decisions give 2^WIDTH codes. One LSB is the reference divided by 2^WIDTH. In full-scale mode, one extra decision first tests the DAC at the reference level itself, code 2^WIDTH, which is carried on the extra top bit of the DAC port. This resolves an intermediate value x from 0 to 2^WIDTH inclusive. The mid-scale code is then dropped, so that both an input of zero and an input at the reference can be represented in WIDTH bits. Each decision waits SETTLE clocks after the trial code changes.

Top module: `sar_adc_ctrl`

## Requirements
- R1: With the controller idle, a high `start` on a clock edge makes `busy` high from the next cycle. While `busy` is high, `start` has no effect on the conversion under way.
- R2: In binary mode (`full_scale`=0), a conversion takes exactly WIDTH decisions of SETTLE cycles each. `busy` is high for WIDTH*SETTLE cycles, and `done` is seen in the cycle right after the last of them.
- R3: Each trial code holds the bits already decided, with the bit under test set to 1 and every lower bit cleared. The bits are tested from the most significant down. `dac_code` is zero whenever `busy` is low.
- R4: A comparator value of 1 keeps the bit under test (the upper half of the range). A value of 0 clears it, and this includes a sample exactly equal to the DAC level. The binary result is therefore the largest code k in 0..2^WIDTH-1 whose trial compared high, or 0 if none did.
- R5: In full-scale mode (`full_scale`=1), the conversion takes WIDTH+1 decisions, so `busy` is high for (WIDTH+1)*SETTLE cycles. The first trial is 2^WIDTH, which is bit WIDTH of `dac_code`. If that trial compares high, then x = 2^WIDTH, `dac_code` stays at 2^WIDTH for the remaining decisions, and the comparator is ignored. Otherwise x is found by an ordinary WIDTH-bit search.
- R6: In full-scale mode the result is x when x < 2^(WIDTH-1), and x-1 otherwise. Zero input gives 0, and an input at the reference gives all ones.
- R7: `done` is high for exactly one cycle. `result` takes its new value in that same cycle, and `busy` falls in that same cycle. `result` stays unchanged until the next `done`.
- R8: `full_scale` is sampled only on the edge that accepts `start`. Changing it during a conversion has no effect on that conversion.
- R9: A synchronous active-low `rst_n` aborts any conversion. It clears `busy`, `done` and `result`, and drives `dac_code` to zero.
- R10: A `start` that is high in the cycle where `done` is high is accepted, so a new conversion begins on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request to begin a conversion |
| full_scale | input | 1 | 0: binary scale, 1: full-scale mode with the extra decision |
| cmp_above | input | 1 | Comparator: 1 when the held sample is above the DAC level |
| dac_code | output | WIDTH+1 | Trial code to the DAC; bit WIDTH is the reference level |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle strobe marking a new result |
| result | output | WIDTH | Converted code |

## Verification
The two functions that can fall in one cycle are the end of a conversion and the acceptance of the next start. The bench provokes this by holding `start` high through the whole of a conversion, so the `done` cycle also carries a request. The bench then judges `busy`, `dac_code` and the second result against a behavioural model that it advances on every clock.

The bench also pulses `start` and toggles `full_scale` in the middle of a conversion to show that both are ignored. Its comparator model places trial code k at (k-1/2) LSB. It sweeps every quarter-LSB input from zero to the reference in both modes, exact ties included.

// File: rtl/sar_pkg.sv
// Package: shared types of the successive approximation sequencer.
// Assumes nothing beyond IEEE 1800-2017 packages.
package sar_pkg;

    // Result scale chosen at the start of a conversion.
    typedef enum logic {
        MODE_BINARY = 1'b0,
        MODE_FULL   = 1'b1
    } sar_mode_e;

endpackage

// File: rtl/sar_settle_timer.sv
// Settle timer: raises tick once every SETTLE busy cycles, so that each
// decision is taken SETTLE cycles after its trial code was presented.
// Assumes launch restarts the count on the edge that begins a conversion.
module sar_settle_timer #(
    parameter int SETTLE = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic run,
    output logic tick
);
    localparam int CW = (SETTLE > 1) ? $clog2(SETTLE) : 1;

    logic [CW-1:0] cnt_q;

    // Decision point: last settle cycle of the current step.
    always_comb tick = run && (cnt_q == CW'(SETTLE - 1));

    // Count settle cycles; restart at launch and after each decision.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (launch || tick) cnt_q <= '0;
        else if (run)            cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/sar_search_core.sv
// Search core: holds the partial code and the index of the bit under test,
// decides one bit per tick and presents the next trial code. In full-scale
// mode the first trial is the reference level (bit WIDTH); once that one
// compares high the code is pinned there for the remaining decisions.
// Assumes cmp_above is valid whenever tick is high.
module sar_search_core
    import sar_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter int SETTLE = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  sar_mode_e       mode_sel,
    input  logic            cmp_above,
    input  logic            tick,
    output logic            busy,
    output logic            launch,
    output logic            finish,
    output logic            fs_mode,
    output logic [WIDTH:0]  x_value,
    output logic [WIDTH:0]  dac_code
);
    localparam int WW = WIDTH + 1;
    localparam int IW = $clog2(WIDTH + 1);
    localparam logic [WIDTH:0] TOP_CODE = WW'(1) << WIDTH;
    localparam logic [WIDTH:0] MID_CODE = WW'(1) << (WIDTH - 1);
    localparam int CYC_BIN  = WIDTH * SETTLE;
    localparam int CYC_FULL = (WIDTH + 1) * SETTLE;

    logic            busy_q;
    logic            fs_q;
    logic [IW-1:0]   idx_q;
    logic [WIDTH:0]  work_q;
    logic [WIDTH:0]  cur_mask;
    logic [WIDTH:0]  next_mask;
    logic [WIDTH:0]  decided;
    logic            last;
    logic            decide;

    // Decision logic: keep the tested bit on a high compare, clear it otherwise.
    always_comb begin
        cur_mask  = WW'(1) << idx_q;
        decided   = cmp_above ? work_q : (work_q & ~cur_mask);
        last      = (idx_q == '0);
        next_mask = (last || (fs_q && decided[WIDTH])) ? '0 : (cur_mask >> 1);
        launch    = start && !busy_q;
        decide    = busy_q && tick;
    end

    // Search state: load the first trial at launch, step one bit per decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            fs_q   <= 1'b0;
            idx_q  <= '0;
            work_q <= '0;
        end else if (launch) begin
            busy_q <= 1'b1;
            fs_q   <= (mode_sel == MODE_FULL);
            idx_q  <= (mode_sel == MODE_FULL) ? IW'(WIDTH) : IW'(WIDTH - 1);
            work_q <= (mode_sel == MODE_FULL) ? TOP_CODE : MID_CODE;
        end else if (decide) begin
            work_q <= decided | next_mask;
            if (last) busy_q <= 1'b0;
            else      idx_q  <= idx_q - 1'b1;
        end
    end

    // Outputs toward the DAC and the result stage.
    always_comb begin
        busy     = busy_q;
        finish   = decide && last;
        fs_mode  = fs_q;
        x_value  = decided;
        dac_code = busy_q ? work_q : '0;
    end

    // Checker-only counter of busy cycles in the current conversion.
    logic [31:0] busy_cycles;
    always_ff @(posedge clk) begin
        if (!rst_n)      busy_cycles <= '0;
        else if (launch) busy_cycles <= '0;
        else if (busy_q) busy_cycles <= busy_cycles + 1'b1;
    end

    AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy_q) |=> busy_q); // R1
    AST_NO_EARLY_END: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !finish) |=> busy_q); // R1
    AST_STEP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        finish |-> (busy_cycles == 32'(fs_q ? CYC_FULL - 1 : CYC_BIN - 1))); // R2
    AST_TOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && fs_q && decided[WIDTH] && !last) |=> (dac_code == TOP_CODE)); // R5

endmodule

// File: rtl/sar_result_map.sv
// Result stage: maps the resolved value onto the output scale and registers
// it together with the one-cycle done strobe. In full-scale mode the mid
// code is removed so that x = 2^WIDTH lands on all ones.
// Assumes x_in never exceeds 2^WIDTH.
module sar_result_map #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             full,
    input  logic [WIDTH:0]   x_in,
    output logic             done,
    output logic [WIDTH-1:0] result
);
    localparam int WW = WIDTH + 1;
    localparam logic [WIDTH:0] HALF = WW'(1) << (WIDTH - 1);

    logic [WIDTH:0] shifted;

    // Scale mapping: drop one code at and above mid scale in full-scale mode.
    always_comb shifted = (full && (x_in >= HALF)) ? (x_in - 1'b1) : x_in;

    // Result register and strobe, updated on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done   <= 1'b0;
            result <= '0;
        end else begin
            done <= take;
            if (take) result <= shifted[WIDTH-1:0];
        end
    end

    AST_MAP_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> !shifted[WIDTH]); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && $past(rst_n)) |-> $stable(result)); // R7

endmodule

// File: rtl/sar_adc_ctrl.sv
// Successive approximation sequencer top: joins the settle timer, the search
// core and the result stage. Assumes the comparator answers within SETTLE
// cycles of a trial code change and that rst_n is synchronous to clk.
module sar_adc_ctrl #(
    parameter int WIDTH  = 8,
    parameter int SETTLE = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             full_scale,
    input  logic             cmp_above,
    output logic [WIDTH:0]   dac_code,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] result
);
    logic           launch;
    logic           tick;
    logic           finish;
    logic           fs_mode;
    logic [WIDTH:0] x_value;

    sar_settle_timer #(.SETTLE(SETTLE)) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .launch (launch),
        .run    (busy),
        .tick   (tick)
    );

    sar_search_core #(.WIDTH(WIDTH), .SETTLE(SETTLE)) core_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .mode_sel  (sar_pkg::sar_mode_e'(full_scale)),
        .cmp_above (cmp_above),
        .tick      (tick),
        .busy      (busy),
        .launch    (launch),
        .finish    (finish),
        .fs_mode   (fs_mode),
        .x_value   (x_value),
        .dac_code  (dac_code)
    );

    sar_result_map #(.WIDTH(WIDTH)) map_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (finish),
        .full   (fs_mode),
        .x_in   (x_value),
        .done   (done),
        .result (result)
    );

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R7

endmodule

// File: tb/sar_adc_ctrl_tb_top.sv
`timescale 1ns/1ps
module sar_adc_ctrl_tb_top;
    localparam int W  = 6;
    localparam int ST = 2;
    localparam int FS = 1 << W;      // codes per reference
    localparam int QREF = 4 * FS;    // reference in quarter-LSB units

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         full_scale = 1'b0;
    logic         cmp_above;
    logic [W:0]   dac_code;
    logic         busy;
    logic         done;
    logic [W-1:0] result;
    int           sample = 0;        // held input in quarter-LSB units

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit running = 0;

    always #2.5 clk = ~clk;

    // Comparator model: trial code k sits at (k - 1/2) LSB.
    assign cmp_above = (sample > 4 * int'(dac_code) - 2);

    sar_adc_ctrl #(.WIDTH(W), .SETTLE(ST)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .full_scale(full_scale),
        .cmp_above(cmp_above), .dac_code(dac_code), .busy(busy),
        .done(done), .result(result)
    );

    task automatic chk(input int act, input int exp, input string tag, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Closed-form expected code for a held input.
    function automatic int ideal(input int s, input bit fs);
        int k = 0;
        int top = fs ? FS : FS - 1;
        for (int j = 1; j <= top; j++) if (s > 4 * j - 2) k = j;
        if (fs) return (k < FS / 2) ? k : k - 1;
        return k;
    endfunction

    // Behavioural cycle model: interval search with lo/hi bounds.
    int m_busy = 0, m_done = 0, m_result = 0, m_dac = 0;
    int m_cnt = 0, m_steps = 0, m_full = 0, m_first = 0, m_top = 0;
    int lo = 0, hi = 0;

    always @(posedge clk) begin
        running = 1;
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_result = 0; m_dac = 0;
        end else begin
            m_done = 0;
            if (m_busy != 0) begin
                m_cnt++;
                if (m_cnt == ST) begin
                    int c;
                    int x;
                    c = (sample > 4 * m_dac - 2) ? 1 : 0;
                    m_cnt = 0;
                    m_steps--;
                    if (m_top != 0) begin
                    end else if (m_first != 0) begin
                        m_first = 0;
                        if (c != 0) m_top = 1;
                        else begin lo = 0; hi = FS - 1; end
                    end else begin
                        if (c != 0) lo = m_dac; else hi = m_dac - 1;
                    end
                    if (m_steps == 0) begin
                        m_busy = 0;
                        x = (m_top != 0) ? FS : lo;
                        m_result = (m_full != 0) ? ((x < FS / 2) ? x : x - 1) : x;
                        m_done = 1;
                        m_dac = 0;
                    end else if (m_top == 0) begin
                        m_dac = (lo + hi + 1) / 2;
                    end
                end
            end else if (start) begin
                m_busy = 1; m_cnt = 0; m_top = 0;
                m_full = full_scale ? 1 : 0;
                if (full_scale) begin
                    m_first = 1; m_steps = W + 1; m_dac = FS;
                end else begin
                    m_first = 0; m_steps = W; lo = 0; hi = FS - 1;
                    m_dac = (lo + hi + 1) / 2;
                end
            end
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (running) begin
            chk(int'(busy), m_busy, rst_n ? "R1" : "R9", "busy");
            chk(int'(done), m_done, rst_n ? "R7" : "R9", "done");
            chk(int'(result), m_result, rst_n ? "R7" : "R9", "result");
            chk(int'(dac_code), m_dac, rst_n ? "R3" : "R9", "dac_code");
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            summary();
            $finish;
        end
    end

    // One conversion; checks latency and the closed-form code.
    task automatic run_conv(input int s, input bit fs, input string tag);
        int n = 0;
        @(negedge clk);
        sample = s; full_scale = fs; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (done !== 1'b1 && n < 200) begin
            @(negedge clk);
            n++;
        end
        chk(n, (fs ? W + 1 : W) * ST, fs ? "R5" : "R2", "latency");
        chk(int'(result), ideal(s, fs), tag, "code");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(int'(busy), 0, "R9", "reset busy");
        chk(int'(dac_code), 0, "R9", "reset dac");
        chk(int'(result), 0, "R9", "reset result");
        rst_n = 1'b1;

        // Named corners.
        run_conv(0, 1'b0, "R4");
        run_conv(126, 1'b0, "R4");          // tie at code 32 -> 31
        chk(int'(result), 31, "R4", "tie lower");
        run_conv(QREF, 1'b0, "R4");
        chk(int'(result), FS - 1, "R4", "binary top");
        run_conv(0, 1'b1, "R6");
        chk(int'(result), 0, "R6", "full zero");
        run_conv(QREF, 1'b1, "R6");
        chk(int'(result), FS - 1, "R6", "full reference");
        run_conv(128, 1'b1, "R6");
        chk(int'(result), FS / 2 - 1, "R6", "full mid removed");
        run_conv(QREF + 8, 1'b1, "R5");     // above reference, code pinned

        // Full sweep in both modes.
        for (int s = 0; s <= QREF; s++) run_conv(s, 1'b0, "R4");
        for (int s = 0; s <= QREF; s++) run_conv(s, 1'b1, "R6");

        // Mode toggled during a conversion is ignored.
        @(negedge clk);
        sample = 200; full_scale = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0; full_scale = 1'b1;
        while (done !== 1'b1) @(negedge clk);
        chk(int'(result), ideal(200, 1'b0), "R8", "mode latched");
        full_scale = 1'b0;

        // Start pulsed during a conversion is ignored.
        @(negedge clk);
        sample = 77; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        begin
            int n = 4;
            while (done !== 1'b1 && n < 200) begin @(negedge clk); n++; end
            chk(n, W * ST, "R1", "latency with stray start");
        end
        chk(int'(result), ideal(77, 1'b0), "R1", "code with stray start");

        // Result holds between conversions.
        repeat (10) @(negedge clk);
        chk(int'(result), ideal(77, 1'b0), "R7", "result held");
        chk(int'(done), 0, "R7", "done low while idle");

        // Start held through done: next conversion begins at once.
        @(negedge clk);
        sample = 40; start = 1'b1;
        @(negedge clk);
        while (done !== 1'b1) @(negedge clk);
        chk(int'(result), ideal(40, 1'b0), "R10", "first of pair");
        sample = 230;
        @(negedge clk);
        start = 1'b0;
        chk(int'(busy), 1, "R10", "busy after done with start");
        while (done !== 1'b1) @(negedge clk);
        chk(int'(result), ideal(230, 1'b0), "R10", "second of pair");

        // Reset in the middle of a conversion.
        @(negedge clk);
        sample = 150; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(int'(busy), 0, "R9", "busy after abort");
        chk(int'(dac_code), 0, "R9", "dac after abort");
        chk(int'(result), 0, "R9", "result after abort");
        rst_n = 1'b1;
        run_conv(150, 1'b1, "R6");

        repeat (4) @(negedge clk);
        summary();
        $finish;
    end
endmodule